// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in-first-out buffer for 18-bit words that crosses between two unrelated clocks. The producer pushes words on the write clock and the consumer pops them on the read clock. The two clocks may run at any rate relative to each other. A push and a pop may occur in the same instant. The storage is a register array of `2**AW` words, and the default depth is 16.

At master reset the block latches one of two read timing modes. In standard mode the read flag reports empty and the write flag reports full. A read that is accepted presents its word on `dout` after the clock edge. In fall-through mode the read flag means that `dout` holds the oldest word, and the write flag means that there is room. The oldest word moves to `dout` without any read request. The block also reports half-full, almost-full and almost-empty. The two almost thresholds come from offset registers. These registers start from one of two preset values and can be reloaded in parallel through the data bus or one bit at a time. A partial reset empties the buffer but keeps the offsets and the mode. Retransmit rewinds the reader to the first word written since the last reset.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave in the order they were written, with writes and reads running at the same time on unrelated clocks.
- R2: Standard mode (`fwft_sel`=0 at master reset). `rd_flag`=1 means empty and `wr_flag`=1 means full. A read taken at a read-clock edge shows its word on `dout` after that edge. `rd_flag` falls within 4 read-clock cycles of the first write into an empty buffer.
- R3: Fall-through mode (`fwft_sel`=1 at master reset). `rd_flag`=1 means `dout` holds the oldest unread word, and `wr_flag`=1 means a write would be accepted. The first word written into an empty buffer reaches `dout` within 4 read-clock cycles without `ren`. `ren` while `rd_flag`=1 consumes that word, and `dout` holds steady while it is not consumed.
- R4: A write while storage is full and a read while storage is empty are ignored. Neither moves a pointer or changes the stored data.
- R5: `half_o`=1 exactly when the stored count exceeds DEPTH/2. In fall-through mode the stored count does not include the word already on `dout`.
- R6: `aempty_o`=1 when the stored count ≤ the empty offset. `afull_o`=1 when the stored count ≥ DEPTH − the full offset.
- R7: Master reset loads both offsets with DEF_A when `def_sel`=0 and with DEF_B when `def_sel`=1.
- R8: Parallel load: with `ld`=1, each cycle with `wen`=1 writes `din[AW-1:0]` into the offsets. The writes alternate, empty offset first and then full offset. The sequence restarts after any cycle with `ld`=0, and no data word is stored.
- R9: Serial load: with `ld`=1, `sen`=1 and `wen`=0, each write clock shifts the register pair {full offset, empty offset} right by one bit and places `si` in the top bit. After 2·AW clocks, the first bit sent is bit 0 of the empty offset.
- R10: Master reset (`mrst_n`=0 for at least two clocks of each domain) empties the buffer, clears `dout` to 0, loads the default offsets and latches `fwft_sel`.
- R11: Partial reset (`prst_n`=0) empties the buffer but keeps the offsets and the timing mode.
- R12: `rt`=1 for one read-clock cycle rewinds reading to the first word written since the last reset. This holds while fewer than DEPTH words have been written since that reset. In fall-through mode that word reappears on `dout` within 3 read-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| fwft_sel | input | 1 | Timing mode sampled during master reset: 1 = fall-through |
| def_sel | input | 1 | Default offset choice sampled during master reset |
| wen | input | 1 | Write enable |
| din | input | DW | Write data, also offset value in parallel load |
| ld | input | 1 | Offset load select |
| sen | input | 1 | Serial offset shift enable |
| si | input | 1 | Serial offset bit |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit request |
| dout | output | DW | Read data |
| wr_flag | output | 1 | Full (standard) or input ready (fall-through) |
| rd_flag | output | 1 | Empty (standard) or output ready (fall-through) |
| half_o | output | 1 | More than half full |
| afull_o | output | 1 | Almost full |
| aempty_o | output | 1 | Almost empty |

## Verification
The hardest state to reach from the ports is a retransmit in fall-through mode while a stale word still sits in the output register. For that word to be stale, the consumer must first drain part of a short burst. The bench therefore writes three words after a partial reset, consumes two, pulses `rt`, and then expects the first word back on `dout` with no read request. A second hard case is streaming with random gaps on both sides and clock periods of 10 ns and 14 ns. This stream hits writes that arrive while the buffer is full and reads that arrive while it is empty, in the middle of the traffic.

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int DW    = 18,
  parameter int AW    = 4,
  parameter int DEF_A = 2,
  parameter int DEF_B = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic          def_sel,
  input  logic          wen,
  input  logic [DW-1:0] din,
  input  logic          ld,
  input  logic          sen,
  input  logic          si,
  input  logic          ren,
  input  logic          rt,
  output logic [DW-1:0] dout,
  output logic          wr_flag,
  output logic          rd_flag,
  output logic          half_o,
  output logic          afull_o,
  output logic          aempty_o
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULLC = PW'(DEPTH);
  localparam logic [PW-1:0] HALFC = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  wire rst_n = mrst_n & prst_n;

  logic          fwft_q;
  logic [AW-1:0] ae_off, af_off;
  logic          ld_sel;

  always_ff @(posedge wclk)
    if (!mrst_n) fwft_q <= fwft_sel;

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      ae_off <= def_sel ? AW'(DEF_B) : AW'(DEF_A);
      af_off <= def_sel ? AW'(DEF_B) : AW'(DEF_A);
      ld_sel <= 1'b0;
    end else if (ld && wen) begin
      if (ld_sel) af_off <= din[AW-1:0];
      else        ae_off <= din[AW-1:0];
      ld_sel <= ~ld_sel;
    end else if (ld && sen) begin
      {af_off, ae_off} <= {si, af_off, ae_off[AW-1:1]};
    end else if (!ld) begin
      ld_sel <= 1'b0;
    end
  end

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rg1, rg2;
  logic [PW-1:0] rbin, rgray, wg1, wg2;

  wire [PW-1:0] wcnt  = wbin - g2b(rg2);
  wire          full  = (wcnt == FULLC);
  wire          wr_go = wen && !ld && !full;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rg1 <= '0; rg2 <= '0;
    end else begin
      rg1 <= rgray;
      rg2 <= rg1;
      if (wr_go) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
    end
  end

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= din;

  logic          ov;
  logic [DW-1:0] dq;
  wire [PW-1:0] rcnt = g2b(wg2) - rbin;
  wire          mt   = (rcnt == '0);
  wire          pop  = !mt && (fwft_q ? (!ov || ren) : ren);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wg1 <= '0; wg2 <= '0; ov <= 1'b0; dq <= '0;
    end else begin
      wg1 <= wgray;
      wg2 <= wg1;
      if (rt) begin
        rbin  <= '0;
        rgray <= '0;
        ov    <= 1'b0;
      end else begin
        if (pop) begin
          rbin  <= rbin + 1'b1;
          rgray <= b2g(rbin + 1'b1);
          dq    <= mem[rbin[AW-1:0]];
        end
        if (fwft_q) begin
          if (pop)      ov <= 1'b1;
          else if (ren) ov <= 1'b0;
        end
      end
    end
  end

  assign dout     = dq;
  assign wr_flag  = fwft_q ? !full : full;
  assign rd_flag  = fwft_q ? ov : mt;
  assign half_o   = wcnt > HALFC;
  assign afull_o  = wcnt >= (FULLC - {1'b0, af_off});
  assign aempty_o = rcnt <= {1'b0, ae_off};

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n) wcnt <= FULLC); // R4
  AST_FULL_HOLD: assert property (@(posedge wclk) disable iff (!rst_n) (full && wen) |=> $stable(wbin)); // R4
  AST_EMPTY_HOLD: assert property (@(posedge rclk) disable iff (!rst_n) (mt && !rt) |=> $stable(rbin)); // R4
  AST_LOAD_NO_DATA: assert property (@(posedge wclk) disable iff (!rst_n) ld |=> $stable(wbin)); // R8
  AST_RT_REWIND: assert property (@(posedge rclk) disable iff (!rst_n) rt |=> (rbin == '0 && !ov)); // R12
  AST_OV_KEEP: assert property (@(posedge rclk) disable iff (!rst_n) (fwft_q && ov && !ren && !rt) |=> (ov && $stable(dq))); // R3
  AST_MODE_HELD: assert property (@(posedge wclk) disable iff (!mrst_n) $stable(fwft_q)); // R10
endmodule

// File: tb/xclk_fifo_bench.sv
module xclk_fifo_bench;
  localparam int DW = 18, AW = 4, DEPTH = 16, DEF_A = 2, DEF_B = 4;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 0, prst_n = 1, fwft_sel = 0, def_sel = 0;
  logic wen = 0, ld = 0, sen = 0, si = 0, ren = 0, rt = 0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic wr_flag, rd_flag, half_o, afull_o, aempty_o;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  xclk_fifo #(.DW(DW), .AW(AW), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_xclk_fifo (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .def_sel(def_sel), .wen(wen), .din(din),
    .ld(ld), .sen(sen), .si(si), .ren(ren), .rt(rt), .dout(dout),
    .wr_flag(wr_flag), .rd_flag(rd_flag), .half_o(half_o),
    .afull_o(afull_o), .aempty_o(aempty_o));

  int q[$], hist[$];
  bit mode;
  int aeo, afo;
  int total = 0, bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_mrst(input bit fw, input bit ds);
    mrst_n = 0; fwft_sel = fw; def_sel = ds;
    wen = 0; ld = 0; sen = 0; ren = 0; rt = 0;
    repeat (4) @(negedge wclk);
    repeat (2) @(negedge rclk);
    @(negedge wclk); mrst_n = 1;
    q.delete(); hist.delete();
    mode = fw; aeo = ds ? DEF_B : DEF_A; afo = aeo;
  endtask

  task automatic do_prst();
    prst_n = 0;
    repeat (3) @(negedge wclk);
    repeat (3) @(negedge rclk);
    @(negedge wclk); prst_n = 1;
    q.delete(); hist.delete();
  endtask

  task automatic settle();
    repeat (5) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic wr(input int v, output bit ok);
    bit isfull;
    @(negedge wclk);
    isfull = mode ? !wr_flag : wr_flag;
    wen = 1; din = DW'(v);
    @(negedge wclk);
    wen = 0;
    ok = !isfull;
    if (ok) begin q.push_back(v); hist.push_back(v); end
  endtask

  task automatic rd(input string tag);
    int n = 0;
    int exp;
    @(negedge rclk);
    while (mode ? !rd_flag : rd_flag) begin
      @(negedge rclk);
      n++;
      if (n > 300) begin chk({tag, " read ready timeout"}, 0, 1); return; end
    end
    if (q.size() == 0) begin chk({tag, " data with empty model"}, 1, 0); return; end
    exp = q.pop_front();
    if (mode) begin
      chk(tag, dout, exp);
      ren = 1; @(negedge rclk); ren = 0;
    end else begin
      ren = 1; @(negedge rclk); ren = 0;
      chk(tag, dout, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    int cnt;
    cnt = mode ? ((q.size() > 0) ? q.size() - 1 : 0) : q.size();
    chk({tag, " R2/R3 wr_flag"}, wr_flag, mode ? (cnt != DEPTH) : (cnt == DEPTH));
    chk({tag, " R2/R3 rd_flag"}, rd_flag, mode ? (q.size() > 0) : (cnt == 0));
    chk({tag, " R5 half"}, half_o, cnt > DEPTH / 2);
    chk({tag, " R6 afull"}, afull_o, cnt >= DEPTH - afo);
    chk({tag, " R6 aempty"}, aempty_o, cnt <= aeo);
  endtask

  task automatic fill_drain(input string tag, input int n, input int base);
    bit ok;
    for (int i = 0; i < n; i++) begin
      wr(base + i, ok);
      settle();
      chk_flags(tag);
    end
    while (q.size() > 0) begin
      rd(tag);
      settle();
      chk_flags(tag);
    end
  endtask

  task automatic stream(input string tag, input int n, input int base);
    fork
      begin
        bit ok;
        for (int i = 0; i < n; i++) begin
          repeat ($urandom_range(2)) @(negedge wclk);
          ok = 0;
          while (!ok) wr(base + i, ok);
        end
      end
      begin
        for (int i = 0; i < n; i++) begin
          repeat ($urandom_range(3)) @(negedge rclk);
          rd(tag);
        end
      end
    join
  endtask

  task automatic par_load(input int e, input int f);
    @(negedge wclk); ld = 1; wen = 1; din = DW'(e);
    @(negedge wclk); din = DW'(f);
    @(negedge wclk); wen = 0; ld = 0;
    aeo = e; afo = f;
  endtask

  task automatic ser_load(input int e, input int f);
    logic [2*AW-1:0] pat;
    pat = {AW'(f), AW'(e)};
    for (int i = 0; i < 2 * AW; i++) begin
      @(negedge wclk); ld = 1; sen = 1; si = pat[i];
    end
    @(negedge wclk); ld = 0; sen = 0; si = 0;
    aeo = e; afo = f;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ok;
    do_mrst(0, 0);
    settle();
    chk("R10 reset dout", dout, 0);
    chk_flags("R10 reset");

    ren = 1; repeat (3) @(negedge rclk); ren = 0;
    chk("R4 read while empty keeps empty", rd_flag, 1);
    wr(18'h100, ok);
    repeat (4) @(negedge rclk);
    chk("R2 first-word latency", rd_flag, 0);
    rd("R4 pointer unmoved by empty read");
    settle();

    fill_drain("R4 fill past full std", DEPTH + 3, 18'h200);
    chk("R7 default offset A", aeo, DEF_A);

    par_load(3, 6);
    settle();
    chk("R8 load stores no data", rd_flag, 1);
    fill_drain("R8 parallel offsets", 11, 18'h300);

    for (int i = 0; i < 5; i++) wr(18'h400 + i, ok);
    do_prst();
    settle();
    chk("R11 partial reset empties", rd_flag, 1);
    for (int i = 0; i < 4; i++) begin
      wr(18'h500 + i, ok);
      settle();
      chk_flags("R11 offsets kept");
    end
    rd("R12 pre-rt"); rd("R12 pre-rt");
    @(negedge rclk); rt = 1; @(negedge rclk); rt = 0;
    q = hist;
    settle();
    chk_flags("R12 after rt std");
    while (q.size() > 0) rd("R12 std reread");

    stream("R1 stream std", 200, 18'h1000);
    settle();
    chk_flags("R1 stream std end");

    do_mrst(1, 1);
    settle();
    chk_flags("R10 reset fwft");
    chk("R7 default offset B", aeo, DEF_B);
    wr(18'h2AA, ok);
    repeat (4) @(negedge rclk);
    chk("R3 fall-through ready", rd_flag, 1);
    chk("R3 fall-through data", dout, 18'h2AA);
    repeat (3) @(negedge rclk);
    chk("R3 dout held", dout, 18'h2AA);
    q.delete(); hist.delete();
    ren = 1; @(negedge rclk); ren = 0;
    settle();
    chk("R3 consumed", rd_flag, 0);
    fill_drain("R4 fill past full fwft", DEPTH + 3, 18'h600);

    ser_load(1, 5);
    settle();
    chk("R9 shift stores no data", rd_flag, 0);
    fill_drain("R9 serial offsets", 12, 18'h700);

    do_prst();
    for (int i = 0; i < 3; i++) wr(18'h800 + i, ok);
    settle();
    rd("R12 pre-rt fwft"); rd("R12 pre-rt fwft");
    @(negedge rclk); rt = 1; @(negedge rclk); rt = 0;
    q = hist;
    repeat (2) @(negedge rclk);
    chk("R12 fwft first word back", dout, 18'h800);
    chk("R12 fwft ready", rd_flag, 1);
    settle();
    chk_flags("R11 mode kept fwft");
    while (q.size() > 0) rd("R12 fwft reread");

    stream("R1 stream fwft", 200, 18'h3000);
    settle();
    chk_flags("R1 stream fwft end");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule